// File: doc/BRIEF.md
# SPI Host Port with Request Handshake

This block connects a parallel word interface to a serial peripheral bus and can act as either the bus master or a bus slave, selected by a mode input. It moves whole words (8, 16 or 24 bits, MSB first) in SPI mode 0: data is captured on the rising SCK edge and changed on the falling edge. An active-low request line paces the words. In slave mode the block drives it low when a transmit word is loaded, and releases it on the first SCK rising edge of that word. In master mode the block reads it. The master starts a word only after seeing the line go high and then low again.

The parallel side has a write strobe that loads the next transmit word and a read strobe that acknowledges a received word. In slave mode the port only acts while the active-low select input is low. While select is high, SCK is ignored and the data output is released. In master mode the select input must stay high. If it goes low, the transfer is aborted and a sticky bus-error flag is raised. The master generates SCK by dividing the system clock with a programmable half-period count. SCK, select, the request input and the slave data input all pass through two-flop synchronizers before edges are detected.

Top module: `spi_host_port`

## Requirements
- R1: In slave mode with `ss_n_in` high, `sdo_oe` is 0 and SCK edges neither advance the bit position nor produce a received word. The next word after select goes low is therefore received and sent intact.
- R2: In slave mode with `ss_n_in` low, after WORD_W rising SCK edges, `rd_data` holds the `sdi` bits captured at those rising edges, first bit in bit WORD_W-1, and `rx_valid` is 1. `sdo` presents the written word MSB first. The first bit is valid before the first rising edge and each later bit follows a falling edge.
- R3: In slave mode, `req_n_out` goes low after a `wr_stb` between words. It returns high after the first rising SCK edge of the next word.
- R4: `req_oe` is 0 during reset, whenever `req_en` is 2'b00, and in master mode. Otherwise it is 1.
- R5: In master mode, `sck_out` idles low and no word starts unless a word has been written. While a word runs, SCK has a period of 2*`half_div` system clocks.
- R6: After a master word completes, no new word starts while `req_n_in` stays low, even with a new word written. A new word starts only after `req_n_in` has been seen high and then low.
- R7: In master mode, `sdo` carries the written word MSB first and `sdi` is sampled on each rising `sck_out`. At the end of the word, `rd_data` holds the sampled word and `rx_valid` is 1.
- R8: In master mode, `ss_n_in` low sets `bus_err` and aborts any transfer (`busy` 0, `sck_out` 0). In slave mode, select low never sets `bus_err`.
- R9: `bus_err` stays set until an `err_clr` pulse. If an error condition is present in the same cycle as the clear, the flag stays set.
- R10: `rd_stb` clears `rx_valid`. Reset leaves `rx_valid`, `bus_err`, `busy` and `sck_out` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 selects master operation, 0 selects slave |
| req_en | input | 2 | Request pin enables; 2'b00 releases the pin |
| half_div | input | DIV_W | SCK half period in system clocks (master) |
| wr_stb | input | 1 | Load `wr_data` as the next transmit word |
| wr_data | input | WORD_W | Transmit word |
| rd_stb | input | 1 | Acknowledge the received word |
| rd_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | A received word is waiting |
| busy | output | 1 | Master transfer in progress |
| err_clr | input | 1 | Clears the bus-error flag (write one) |
| bus_err | output | 1 | Sticky bus-error flag |
| sck_in | input | 1 | Serial clock from the bus (slave) |
| sck_out | output | 1 | Serial clock generated (master) |
| ss_n_in | input | 1 | Active-low select input |
| sdi | input | 1 | Serial data in (MOSI as slave, MISO as master) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| req_n_in | input | 1 | Active-low request from an external slave |
| req_n_out | output | 1 | Active-low ready request to an external master |
| req_oe | output | 1 | Output enable for the request pin |

## Verification
Two events can fall in the same cycle: detection of a select-low bus error and a write-one clear of the error flag. The bench aborts a running master word by pulling select low. It then pulses the clear while select is still low, and requires the flag to stay set. After select rises, the flag must still persist until a second clear removes it. A second collision comes from a transmit write arriving just as a master word ends while the request line is still low. Here the bench requires that no SCK appears until the request line has gone high and low again.

// File: rtl/spi_hp_pkg.sv
package spi_hp_pkg;

   typedef enum logic [1:0] {
      MS_IDLE = 2'd0,
      MS_LOW  = 2'd1,
      MS_HIGH = 2'd2
   } mst_st_t;

   function automatic bit width_ok(input int w);
      return (w == 8) || (w == 16) || (w == 24);
   endfunction

endpackage

// File: rtl/spi_hp_sync.sv
module spi_hp_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_hp_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_hp_div.sv
module spi_hp_div #(
   parameter int DIV_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim  = (half == '0) ? '0 : half - 1'b1;
   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || tick)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/spi_hp_shreg.sv
module spi_hp_shreg #(
   parameter int W = 24
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         samp_en,
   input  logic         samp_bit,
   output logic         msb,
   output logic [W-1:0] word
);

   logic [W-1:0] sh;
   logic         samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         samp <= 1'b0;
      end else begin
         if (load)       sh <= load_val;
         else if (shift) sh <= {sh[W-2:0], samp};
         if (samp_en)    samp <= samp_bit;
      end
   end

   assign msb  = sh[W-1];
   assign word = {sh[W-2:0], samp_bit};

endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
   import spi_hp_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic [1:0]        req_en,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              wr_stb,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_stb,
   output logic [WORD_W-1:0] rd_data,
   output logic              rx_valid,
   output logic              busy,
   input  logic              err_clr,
   output logic              bus_err,
   input  logic              sck_in,
   output logic              sck_out,
   input  logic              ss_n_in,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              req_n_in,
   output logic              req_n_out,
   output logic              req_oe
);

   localparam int              CNT_W    = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   generate
      if (!width_ok(WORD_W)) begin : g_bad_width
         $error("WORD_W must be 8, 16 or 24");
      end
   endgenerate

   // synchronised bus inputs: {sck, ss_n, sdi, req_n}
   logic [3:0] sync_q;
   logic       sck_s, ss_s, sdi_s, req_s, sck_d;

   spi_hp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck_in, ss_n_in, sdi, req_n_in}),
      .q     (sync_q)
   );

   assign {sck_s, ss_s, sdi_s, req_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   logic mst_tick;
   mst_st_t mst_st;
   logic [CNT_W-1:0] bit_cnt;
   logic pending, armed, rdy;

   wire sck_rise  = sck_s & ~sck_d;
   wire sck_fall  = ~sck_s & sck_d;
   wire slave_act = !master_mode && !ss_s;
   wire err_det   = master_mode && !ss_s;
   wire mid_word  = (bit_cnt != '0);

   wire s_rise  = slave_act && sck_rise;
   wire s_fall  = slave_act && sck_fall && mid_word;
   wire m_rise  = master_mode && (mst_st == MS_LOW) && mst_tick && !err_det;
   wire m_fall  = master_mode && (mst_st == MS_HIGH) && mst_tick && mid_word && !err_det;
   wire rise_ev = s_rise || m_rise;
   wire fall_ev = s_fall || m_fall;
   wire cap_bit = master_mode ? sdi : sdi_s;
   wire word_done = rise_ev && (bit_cnt == LAST_BIT);
   wire load    = wr_stb && (master_mode ? (mst_st == MS_IDLE)
                                         : (!mid_word && !rise_ev));
   wire start   = master_mode && (mst_st == MS_IDLE) && pending && armed
                  && !req_s && !err_det;

   spi_hp_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mst_st != MS_IDLE),
      .half  (half_div),
      .tick  (mst_tick)
   );

   logic [WORD_W-1:0] asm_word;
   logic              sh_msb;

   spi_hp_shreg #(.W(WORD_W)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (wr_data),
      .shift    (fall_ev),
      .samp_en  (rise_ev),
      .samp_bit (cap_bit),
      .msb      (sh_msb),
      .word     (asm_word)
   );

   // master sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_st  <= MS_IDLE;
         sck_out <= 1'b0;
      end else if (!master_mode || err_det) begin
         mst_st  <= MS_IDLE;
         sck_out <= 1'b0;
      end else begin
         unique case (mst_st)
            MS_IDLE: if (start) mst_st <= MS_LOW;
            MS_LOW: if (mst_tick) begin
               sck_out <= 1'b1;
               mst_st  <= MS_HIGH;
            end
            MS_HIGH: if (mst_tick) begin
               sck_out <= 1'b0;
               mst_st  <= mid_word ? MS_LOW : MS_IDLE;
            end
            default: mst_st <= MS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pending <= 1'b0;
      else if (!master_mode || err_det)    pending <= 1'b0;
      else if (start)                      pending <= 1'b0;
      else if (load)                       pending <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed <= 1'b0;
      else if (start)  armed <= 1'b0;
      else if (req_s)  armed <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bit_cnt <= '0;
      else if (master_mode ? (err_det || mst_st == MS_IDLE) : ss_s)
         bit_cnt <= '0;
      else if (rise_ev)
         bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rdy <= 1'b0;
      else if (master_mode)             rdy <= 1'b0;
      else if (s_rise && !mid_word)     rdy <= 1'b0;
      else if (load)                    rdy <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         if (word_done) rd_data <= asm_word;
         if (word_done)   rx_valid <= 1'b1;
         else if (rd_stb) rx_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bus_err <= 1'b0;
      else if (err_det)  bus_err <= 1'b1;
      else if (err_clr)  bus_err <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_oe <= 1'b0;
      else        req_oe <= !master_mode && (req_en != 2'b00);
   end

   assign sdo       = sh_msb;
   assign sdo_oe    = master_mode | ~ss_s;
   assign busy      = (mst_st != MS_IDLE);
   assign req_n_out = ~rdy;

   // guards next to the logic above
   assert_ignore_sck_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && ss_s) |=> $stable(rd_data));

   assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_act && sck_rise && !mid_word) |=> req_n_out);

   assert_req_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en == 2'b00) |=> !req_oe);

   assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_st == MS_IDLE) |-> !sck_out);

   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && !ss_s) |=> (!busy && bus_err));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !err_clr) |=> bus_err);

   assert_rx_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> rx_valid);

endmodule

// File: tb/spi_host_port_bench.sv
module spi_host_port_bench;

   localparam int W  = 8;
   localparam int DW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          master_mode = 1'b0;
   logic [1:0]    req_en = 2'b11;
   logic [DW-1:0] half_div = 4'd1;
   logic          wr_stb = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic          rd_stb = 1'b0;
   logic [W-1:0]  rd_data;
   logic          rx_valid, busy, bus_err;
   logic          err_clr = 1'b0;
   logic          sck_in = 1'b0;
   logic          sck_out;
   logic          ss_n_in = 1'b1;
   logic          sdi, sdo, sdo_oe;
   logic          req_n_in = 1'b1;
   logic          req_n_out, req_oe;

   logic          sdi_drv = 1'b0;
   logic          m_sdi;
   logic [W-1:0]  m_word = '0;
   logic [W-1:0]  m_got = '0;
   int            m_idx = 0;
   int            m_base = 0;
   int            cyc = 0;
   int            last_rise = 0;
   int            m_period = 0;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   spi_host_port #(.WORD_W(W), .DIV_W(DW)) u_spi_host_port (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .req_en(req_en),
      .half_div(half_div), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
      .rd_data(rd_data), .rx_valid(rx_valid), .busy(busy), .err_clr(err_clr),
      .bus_err(bus_err), .sck_in(sck_in), .sck_out(sck_out), .ss_n_in(ss_n_in),
      .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .req_n_in(req_n_in),
      .req_n_out(req_n_out), .req_oe(req_oe)
   );

   // external slave model used in master mode
   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge sck_out) begin
      m_got     <= {m_got[W-2:0], sdo};
      m_idx     <= m_idx + 1;
      m_period  <= cyc - last_rise;
      last_rise <= cyc;
   end
   always_comb begin
      if ((m_idx - m_base) >= 0 && (m_idx - m_base) < W)
         m_sdi = m_word[W-1-(m_idx-m_base)];
      else
         m_sdi = 1'b0;
   end
   assign sdi = master_mode ? m_sdi : sdi_drv;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic write_word(input logic [W-1:0] v);
      wr_data = v;
      wr_stb  = 1'b1;
      tick(1);
      wr_stb  = 1'b0;
   endtask

   task automatic read_ack();
      rd_stb = 1'b1;
      tick(1);
      rd_stb = 1'b0;
      tick(1);
   endtask

   task automatic slave_word(input logic [W-1:0] tx, input logic [W-1:0] rx);
      logic [W-1:0] got;
      write_word(tx);
      tick(4);
      chk(req_n_out == 1'b0, "R3 ready low", req_n_out, 0);
      ss_n_in = 1'b0;
      tick(8);
      got = '0;
      for (int b = 0; b < W; b++) begin
         sdi_drv = rx[W-1-b];
         tick(8);
         got = {got[W-2:0], sdo};
         sck_in = 1'b1;
         tick(8);
         if (b == 0) chk(req_n_out == 1'b1, "R3 ready released", req_n_out, 1);
         sck_in = 1'b0;
      end
      tick(8);
      chk(rx_valid && rd_data == rx, "R2 slave receive", rd_data, rx);
      chk(got == tx, "R2 slave send", got, tx);
      ss_n_in = 1'b1;
      tick(4);
      chk(sdo_oe == 1'b0, "R1 sdo released", sdo_oe, 0);
      read_ack();
      chk(rx_valid == 1'b0, "R10 read clears", rx_valid, 0);
   endtask

   task automatic master_word(input logic [W-1:0] tx, input logic [W-1:0] rx,
                              input logic [DW-1:0] h);
      int lim;
      half_div = h;
      req_n_in = 1'b1;
      tick(4);
      m_word = rx;
      m_base = m_idx;
      write_word(tx);
      req_n_in = 1'b0;
      lim = 0;
      while (!busy && lim < 50) begin tick(1); lim++; end
      chk(busy == 1'b1, "R5 word started", busy, 1);
      lim = 0;
      while (busy && lim < 500) begin tick(1); lim++; end
      tick(3);
      chk(rx_valid && rd_data == rx, "R7 master receive", rd_data, rx);
      chk(m_got == tx, "R7 master send", m_got, tx);
      chk(m_period == 2 * int'(h), "R5 sck period", m_period, 2 * int'(h));
      read_ack();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      tick(3);
      chk(req_oe == 1'b0, "R4 oe in reset", req_oe, 0);
      rst_n = 1'b1;
      tick(3);
      chk(rx_valid == 1'b0 && bus_err == 1'b0, "R10 reset flags", {rx_valid, bus_err}, 0);
      chk(busy == 1'b0 && sck_out == 1'b0, "R5 reset idle", {busy, sck_out}, 0);
      chk(req_oe == 1'b1, "R4 oe enabled", req_oe, 1);
      req_en = 2'b00;
      tick(2);
      chk(req_oe == 1'b0, "R4 oe both clear", req_oe, 0);
      req_en = 2'b10;
      tick(2);
      chk(req_oe == 1'b1, "R4 oe one set", req_oe, 1);

      // R1: select high, clocks must be ignored
      for (int p = 0; p < 5; p++) begin
         sdi_drv = p[0];
         sck_in = 1'b1; tick(8);
         sck_in = 1'b0; tick(8);
      end
      chk(rx_valid == 1'b0 && sdo_oe == 1'b0, "R1 deselected", {rx_valid, sdo_oe}, 0);
      slave_word(8'h3C, 8'hC5);

      // R2 sweep over every slave word
      for (int i = 0; i < 256; i++) begin
         slave_word(W'(i), W'(i) ^ 8'hA5);
      end
      chk(bus_err == 1'b0, "R8 no error as slave", bus_err, 0);

      // master mode
      master_mode = 1'b1;
      tick(3);
      chk(req_oe == 1'b0, "R4 oe master", req_oe, 0);
      for (int i = 0; i < 256; i++) begin
         master_word(W'((i * 37) % 256), W'(i), DW'(1 + (i % 3)));
      end

      // R6: request still low after a word
      m_base = m_idx;
      m_word = 8'h96;
      write_word(8'h69);
      tick(40);
      chk(busy == 1'b0 && sck_out == 1'b0, "R6 waits fresh request", {busy, sck_out}, 0);
      master_word(8'h69, 8'h96, 4'd2);

      // R5: fresh request but nothing written
      req_n_in = 1'b1; tick(4);
      req_n_in = 1'b0; tick(30);
      chk(busy == 1'b0, "R5 no word pending", busy, 0);

      // R8/R9: select low while master
      half_div = 4'd4;
      req_n_in = 1'b1; tick(4);
      m_base = m_idx;
      write_word(8'hF0);
      req_n_in = 1'b0;
      tick(20);
      chk(busy == 1'b1, "R8 word running", busy, 1);
      ss_n_in = 1'b0;
      tick(5);
      chk(bus_err == 1'b1, "R8 error flagged", bus_err, 1);
      chk(busy == 1'b0 && sck_out == 1'b0, "R8 aborted", {busy, sck_out}, 0);
      err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
      chk(bus_err == 1'b1, "R9 set beats clear", bus_err, 1);
      ss_n_in = 1'b1;
      tick(6);
      chk(bus_err == 1'b1, "R9 sticky", bus_err, 1);
      err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
      chk(bus_err == 1'b0, "R9 cleared", bus_err, 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule